// File: doc/BRIEF.md
# Bit-Flipping Scan Pattern Generator

This block produces the scan-in stream for a test-per-scan self-test session. A small linear feedback shift register supplies pseudo-random bits. A bit counter gives the position of the current bit inside the scan chain. A pattern counter gives the number of the current pattern. Each bit goes out on the scan data output while scan enable is high. A combinational flip function can invert the bit before it leaves, so that chosen random patterns become the deterministic patterns a test needs.

The flip function is a sum of programmable cubes. Each cube has a care mask, a value and an enable flag. Every cube is compared with the vector formed from the pattern counter, the bit counter and the register state. If any enabled cube matches, the output bit is inverted. Cubes are written through a small configuration port while no run is in progress. A run starts with a start pulse. It lasts one clock per scan bit for every pattern, and it ends with done held high until the next start.

Top module: `bf_pattern_gen`

## Requirements
- R1: After reset, scanEn, done, scanOut and patIdx are all 0, and every cube is disabled.
- R2: A start pulse while no run is active makes scanEn high from the next cycle on, for exactly SCAN_LEN*PAT_COUNT consecutive cycles (30 by default).
- R3: During a run, patIdx holds each value for SCAN_LEN consecutive scan cycles and steps 0, 1, ... up to PAT_COUNT-1. The bit position counts 0 to SCAN_LEN-1 inside each pattern.
- R4: done goes high in the cycle after the last scan bit and stays high, with scanEn low and patIdx at PAT_COUNT-1, until the next start.
- R5: The register loads the seed 2'b01 at every start and steps as next = {s[1]^s[0], s[1]}. With no cube enabled, scanOut equals s[0], which gives the bits 1,0,1 repeating from the first scan cycle.
- R6: The match vector is {patIdx[2:0], bitPos[2:0], s[1:0]}, with bit 7 as its MSB. A cube matches when ((vector ^ value) & mask) == 0 and its enable flag is set. When any enabled cube matches, scanOut is the inverse of s[0].
- R7: Configuration writes made while scanEn is high are ignored.
- R8: A write with cfgOn=0 disables that cube, so it no longer affects scanOut.
- R9: A start pulse during a run is ignored: the run keeps its length and its bit stream.
- R10: scanOut is 0 whenever scanEn is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Starts a run when no run is active |
| cfgWe | input | 1 | Cube write strobe |
| cfgIdx | input | 2 | Index of the cube to write |
| cfgOn | input | 1 | Enable flag written to the cube |
| cfgMask | input | 8 | Care mask written to the cube |
| cfgValue | input | 8 | Match value written to the cube |
| scanOut | output | 1 | Scan data bit |
| scanEn | output | 1 | High while scan bits are being produced |
| patIdx | output | 3 | Current pattern number |
| done | output | 1 | High after a completed run |

## Verification
The hardest case to reach from the ports is a configuration write or a start pulse that arrives in the middle of a run. The stimulus injects these in chosen scan cycles. It writes a cube with an all-zero mask, which would invert every later bit if the write were accepted, and the whole stream is then compared against a model that kept the old cube set. Random cube sets place matches at varied pattern, position and register-state combinations. Directed runs cover the empty list, a cube that matches everything, and the removal of a cube.

// File: rtl/bf_pkg.sv
package bf_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_RUN  = 2'd1,
    PH_FIN  = 2'd2
  } phase_t;

  typedef struct packed {
    logic seedLoad;
    logic step;
    logic cfgOpen;
  } ctrlStrobe_t;

endpackage

// File: rtl/bf_ctrl.sv
module bf_ctrl
  import bf_pkg::*;
#(
  parameter int SCAN_LEN  = 5,
  parameter int PAT_COUNT = 6,
  parameter int BIT_W     = 3,
  parameter int PAT_W     = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  output ctrlStrobe_t      strobe,
  output logic [BIT_W-1:0] bitCnt,
  output logic [PAT_W-1:0] patCnt,
  output logic             running,
  output logic             finished
);

  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(SCAN_LEN - 1);
  localparam logic [PAT_W-1:0] PAT_LAST = PAT_W'(PAT_COUNT - 1);

  phase_t phase;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase  <= PH_IDLE;
      bitCnt <= '0;
      patCnt <= '0;
    end else begin
      case (phase)
        PH_RUN: begin
          if (bitCnt == BIT_LAST) begin
            bitCnt <= '0;
            if (patCnt == PAT_LAST) phase <= PH_FIN;
            else patCnt <= patCnt + 1'b1;
          end else begin
            bitCnt <= bitCnt + 1'b1;
          end
        end
        default: begin
          if (start) begin
            phase  <= PH_RUN;
            bitCnt <= '0;
            patCnt <= '0;
          end
        end
      endcase
    end
  end

  always_comb begin
    running         = (phase == PH_RUN);
    finished        = (phase == PH_FIN);
    strobe.step     = running;
    strobe.seedLoad = !running && start;
    strobe.cfgOpen  = !running;
  end

endmodule

// File: rtl/bf_datapath.sv
module bf_datapath
  import bf_pkg::*;
#(
  parameter int              LFSR_W  = 2,
  parameter logic [LFSR_W-1:0] TAPS  = 2'b11,
  parameter logic [LFSR_W-1:0] SEED  = 2'b01,
  parameter int              CUBES   = 4,
  parameter int              BIT_W   = 3,
  parameter int              PAT_W   = 3,
  parameter int              IDX_W   = 2,
  parameter int              MATCH_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobe_t        strobe,
  input  logic [BIT_W-1:0]   bitCnt,
  input  logic [PAT_W-1:0]   patCnt,
  input  logic               cfgWe,
  input  logic [IDX_W-1:0]   cfgIdx,
  input  logic               cfgOn,
  input  logic [MATCH_W-1:0] cfgMask,
  input  logic [MATCH_W-1:0] cfgValue,
  output logic               scanBit
);

  logic [LFSR_W-1:0]  lfsrQ;
  logic               feedback;
  logic [MATCH_W-1:0] matchVec;
  logic [CUBES-1:0]   hit;
  logic               flip;

  assign feedback = ^(lfsrQ & TAPS);

  always_ff @(posedge clk) begin
    if (!rstN) lfsrQ <= SEED;
    else if (strobe.seedLoad) lfsrQ <= SEED;
    else if (strobe.step) lfsrQ <= {feedback, lfsrQ[LFSR_W-1:1]};
  end

  assign matchVec = {patCnt, bitCnt, lfsrQ};

  for (genvar g = 0; g < CUBES; g++) begin : g_cube
    logic [MATCH_W-1:0] maskQ;
    logic [MATCH_W-1:0] valueQ;
    logic               onQ;
    logic               sel;

    assign sel = cfgWe && strobe.cfgOpen && (cfgIdx == IDX_W'(g));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        maskQ  <= '0;
        valueQ <= '0;
        onQ    <= 1'b0;
      end else if (sel) begin
        maskQ  <= cfgMask;
        valueQ <= cfgValue;
        onQ    <= cfgOn;
      end
    end

    assign hit[g] = onQ && (((matchVec ^ valueQ) & maskQ) == '0);
  end

  assign flip    = |hit;
  assign scanBit = strobe.step & (lfsrQ[0] ^ flip);

endmodule

// File: rtl/bf_pattern_gen.sv
module bf_pattern_gen
  import bf_pkg::*;
#(
  parameter int SCAN_LEN  = 5,
  parameter int PAT_COUNT = 6,
  parameter int LFSR_W    = 2,
  parameter logic [LFSR_W-1:0] TAPS = 2'b11,
  parameter logic [LFSR_W-1:0] SEED = 2'b01,
  parameter int CUBES     = 4,
  localparam int BIT_W    = (SCAN_LEN > 1) ? $clog2(SCAN_LEN) : 1,
  localparam int PAT_W    = (PAT_COUNT > 1) ? $clog2(PAT_COUNT) : 1,
  localparam int IDX_W    = (CUBES > 1) ? $clog2(CUBES) : 1,
  localparam int MATCH_W  = PAT_W + BIT_W + LFSR_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic               cfgWe,
  input  logic [IDX_W-1:0]   cfgIdx,
  input  logic               cfgOn,
  input  logic [MATCH_W-1:0] cfgMask,
  input  logic [MATCH_W-1:0] cfgValue,
  output logic               scanOut,
  output logic               scanEn,
  output logic [PAT_W-1:0]   patIdx,
  output logic               done
);

  ctrlStrobe_t      strobe;
  logic [BIT_W-1:0] bitCnt;
  logic [PAT_W-1:0] patCnt;

  bf_ctrl #(
    .SCAN_LEN (SCAN_LEN),
    .PAT_COUNT(PAT_COUNT),
    .BIT_W    (BIT_W),
    .PAT_W    (PAT_W)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .strobe  (strobe),
    .bitCnt  (bitCnt),
    .patCnt  (patCnt),
    .running (scanEn),
    .finished(done)
  );

  bf_datapath #(
    .LFSR_W (LFSR_W),
    .TAPS   (TAPS),
    .SEED   (SEED),
    .CUBES  (CUBES),
    .BIT_W  (BIT_W),
    .PAT_W  (PAT_W),
    .IDX_W  (IDX_W),
    .MATCH_W(MATCH_W)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .bitCnt  (bitCnt),
    .patCnt  (patCnt),
    .cfgWe   (cfgWe),
    .cfgIdx  (cfgIdx),
    .cfgOn   (cfgOn),
    .cfgMask (cfgMask),
    .cfgValue(cfgValue),
    .scanBit (scanOut)
  );

  assign patIdx = patCnt;

endmodule

// File: rtl/bf_pattern_gen_chk.sv
module bf_pattern_gen_chk #(
  parameter int SCAN_LEN  = 5,
  parameter int PAT_COUNT = 6,
  parameter int PAT_W     = 3
) (
  input logic             clk,
  input logic             rstN,
  input logic             start,
  input logic             scanOut,
  input logic             scanEn,
  input logic [PAT_W-1:0] patIdx,
  input logic             done
);

  localparam int TOTAL = SCAN_LEN * PAT_COUNT;

  logic [15:0] runCnt;

  always_ff @(posedge clk) begin
    if (!rstN) runCnt <= '0;
    else if (scanEn) runCnt <= runCnt + 1'b1;
    else if (start) runCnt <= '0;
  end

  assert_excl_R4: assert property (@(posedge clk) disable iff (!rstN)
    !(scanEn && done));

  assert_idle_zero_R10: assert property (@(posedge clk) disable iff (!rstN)
    !scanEn |-> !scanOut);

  assert_start_R2: assert property (@(posedge clk) disable iff (!rstN)
    (start && !scanEn) |=> scanEn);

  assert_run_len_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> (runCnt == 16'(TOTAL)));

  assert_pat_range_R3: assert property (@(posedge clk) disable iff (!rstN)
    patIdx <= PAT_W'(PAT_COUNT - 1));

  assert_pat_step_R3: assert property (@(posedge clk) disable iff (!rstN)
    scanEn |=> (patIdx == $past(patIdx)) || (patIdx == $past(patIdx) + 1'b1));

  assert_done_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    (done && !start) |=> done);

  assert_run_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (scanEn && start && runCnt < 16'(TOTAL - 1)) |=> scanEn);

endmodule

bind bf_pattern_gen bf_pattern_gen_chk #(
  .SCAN_LEN (SCAN_LEN),
  .PAT_COUNT(PAT_COUNT),
  .PAT_W    (PAT_W)
) u_chk (
  .clk    (clk),
  .rstN   (rstN),
  .start  (start),
  .scanOut(scanOut),
  .scanEn (scanEn),
  .patIdx (patIdx),
  .done   (done)
);

// File: tb/sim_bf_pattern_gen.sv
module sim_bf_pattern_gen;

  localparam int CLK_PERIOD = 10;
  localparam int SCAN_LEN   = 5;
  localparam int PAT_COUNT  = 6;
  localparam int TOTAL      = SCAN_LEN * PAT_COUNT;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       start = 1'b0;
  logic       cfgWe = 1'b0;
  logic [1:0] cfgIdx = '0;
  logic       cfgOn = 1'b0;
  logic [7:0] cfgMask = '0;
  logic [7:0] cfgValue = '0;
  logic       scanOut;
  logic       scanEn;
  logic [2:0] patIdx;
  logic       done;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  logic [7:0] mMask  [4];
  logic [7:0] mValue [4];
  logic       mOn    [4];

  bf_pattern_gen u0 (
    .clk(clk), .rstN(rstN), .start(start), .cfgWe(cfgWe), .cfgIdx(cfgIdx),
    .cfgOn(cfgOn), .cfgMask(cfgMask), .cfgValue(cfgValue),
    .scanOut(scanOut), .scanEn(scanEn), .patIdx(patIdx), .done(done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic modelFlip(input logic [2:0] p, input logic [2:0] b,
                                     input logic [1:0] s);
    logic [7:0] v;
    logic f;
    v = {p, b, s};
    f = 1'b0;
    for (int i = 0; i < 4; i++)
      if (mOn[i] && (((v ^ mValue[i]) & mMask[i]) == 8'h00)) f = 1'b1;
    return f;
  endfunction

  task automatic writeCube(input int idx, input logic on, input logic [7:0] mk,
                           input logic [7:0] val);
    @(negedge clk);
    cfgWe = 1'b1; cfgIdx = 2'(idx); cfgOn = on; cfgMask = mk; cfgValue = val;
    @(negedge clk);
    cfgWe = 1'b0;
    mOn[idx] = on; mMask[idx] = mk; mValue[idx] = val;
  endtask

  // one complete run; optional injected write (R7) and start (R9) mid-run
  task automatic runTest(input string tag, input bit inject);
    logic [1:0] s;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    s = 2'b01;
    for (int k = 0; k < TOTAL; k++) begin
      logic expBit;
      expBit = s[0] ^ modelFlip(3'(k / SCAN_LEN), 3'(k % SCAN_LEN), s);
      check({tag, " R2 scanEn"}, int'(scanEn), 1);
      check({tag, " R3 patIdx"}, int'(patIdx), k / SCAN_LEN);
      check({tag, " R6 scanOut"}, int'(scanOut), int'(expBit));
      cfgWe = 1'b0;
      start = 1'b0;
      if (inject && k == 9) begin
        cfgWe = 1'b1; cfgIdx = 2'd3; cfgOn = 1'b1; cfgMask = 8'h00; cfgValue = 8'h00;
      end
      if (inject && k == 14) start = 1'b1;
      s = {s[1] ^ s[0], s[1]};
      @(negedge clk);
    end
    cfgWe = 1'b0;
    start = 1'b0;
    check({tag, " R4 done"}, int'(done), 1);
    check({tag, " R4 scanEn low"}, int'(scanEn), 0);
    check({tag, " R10 scanOut idle"}, int'(scanOut), 0);
    @(negedge clk);
    @(negedge clk);
    check({tag, " R4 done held"}, int'(done), 1);
    check({tag, " R4 patIdx last"}, int'(patIdx), PAT_COUNT - 1);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        errors++;
        checks++;
        $display("FAIL watchdog R2 actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd4051));
    for (int i = 0; i < 4; i++) begin
      mOn[i] = 1'b0; mMask[i] = '0; mValue[i] = '0;
    end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 scanEn", int'(scanEn), 0);
    check("R1 done", int'(done), 0);
    check("R1 patIdx", int'(patIdx), 0);
    check("R1 scanOut", int'(scanOut), 0);

    // R1/R5: cubes disabled after reset, plain register sequence
    runTest("R1_R5 empty", 1'b0);

    // R6: two example cubes on pattern bit0 with state bit0 or position bit0
    writeCube(0, 1'b1, 8'b0010_0001, 8'b0000_0001);
    writeCube(1, 1'b1, 8'b0010_0100, 8'b0000_0100);
    runTest("R6 pair", 1'b0);

    // R7/R9: mid-run write and start must be ignored
    runTest("R7_R9 inject", 1'b1);

    // R8: remove cubes, stream returns to plain sequence
    writeCube(0, 1'b0, 8'b0010_0001, 8'b0000_0001);
    writeCube(1, 1'b0, 8'b0010_0100, 8'b0000_0100);
    writeCube(3, 1'b0, 8'h00, 8'h00);
    runTest("R8 removed", 1'b0);

    // R6: mask zero cube inverts every bit
    writeCube(2, 1'b1, 8'h00, 8'h5a);
    runTest("R6 all", 1'b0);
    writeCube(2, 1'b0, 8'h00, 8'h00);

    // R5/R6/R10 random cube sets, seed reload each start
    for (int r = 0; r < 8; r++) begin
      for (int c = 0; c < 4; c++) begin
        logic [7:0] mk;
        mk = 8'($urandom) | 8'($urandom);
        writeCube(c, 1'($urandom), mk, 8'($urandom));
      end
      runTest("R5_R6 random", 1'b0);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule